// File: doc/BRIEF.md
# Windowed Image Scan-Out Engine

This block drives a 640x480, 60 Hz video raster from a picture held in a synchronous on-chip ROM. The picture is 300 by 300 pixels, stored row-major with 12 bits per pixel: red in bits 11:8, green in bits 7:4 and blue in bits 3:0. The picture sits in a window at the top-left corner of the active area, columns 0 to 299 and rows 0 to 299. Every other screen position is driven black.

The block runs on a single 100 MHz system clock. It makes its own pixel-rate strobe by dividing that clock by four, so no derived clock is used. The horizontal and vertical counters produce active-low sync pulses. The ROM address is computed from the raster position as row base plus column, where the row base steps by the picture width on each picture line. The ROM returns data one strobe after it sees an address. Sync and the window flag are delayed by matching stages, so the colour word, both sync levels and the window decision for a given pixel all leave their output registers on the same strobe.

All sizes are parameters. The defaults give the 640x480 raster and the 300x300 picture; a bench can shrink them.

Top module: `img_window_scan`

## Requirements
- R1: `pix_ce` is high for exactly one system clock in every DIV clocks.
- R2: While `rst` is high, after one clock edge, `hsync_n` and `vsync_n` are 1, `rgb` is 0, `rom_addr` is 0 and `pix_ce` is 0.
- R3: A line lasts H_ACT+H_FP+H_SW+H_BP pixels. `hsync_n` is 0 for exactly the pixels at columns H_ACT+H_FP up to H_ACT+H_FP+H_SW-1, and 1 elsewhere.
- R4: A frame lasts V_ACT+V_FP+V_SW+V_BP lines. `vsync_n` is 0 for every pixel of lines V_ACT+V_FP up to V_ACT+V_FP+V_SW-1, and 1 elsewhere.
- R5: For a raster pixel at column h and line v with h < PIC_W and v < PIC_H, `rom_addr` is v*PIC_W+h one strobe after the counters reach that pixel. Each picture row therefore starts at its own row address, and the count restarts at 0 each frame.
- R6: For a pixel outside the window, `rom_addr` is 0, and it never reaches PIC_W*PIC_H.
- R7: For a pixel inside the window, `rgb` equals the ROM word at v*PIC_W+h. It appears on the same strobe as that pixel's `hsync_n` and `vsync_n` levels, three strobes after the counters reach the pixel.
- R8: For any pixel with h >= PIC_W or v >= PIC_H, including the blanking intervals, `rgb` is 0.
- R9: `rgb`, `hsync_n` and `vsync_n` change only on clock edges where `pix_ce` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (100 MHz nominal) |
| rst | input | 1 | Synchronous reset, active high |
| pix_ce | output | 1 | Pixel-rate strobe, one clock in DIV |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| rgb | output | 12 | Colour: red 11:8, green 7:4, blue 3:0 |
| rom_addr | output | ADDR_W | Picture ROM read address |
| rom_data | input | 12 | Picture ROM read data, one strobe after the address |

## Verification
The hardest condition to reach is a full pass through the row-base stepping: every picture row start, the rows below the picture where the address must stay 0, and the wrap back to address 0 at the frame boundary.

A full-size frame takes too many cycles to simulate, so the bench shrinks the raster and the picture through the parameters. It then runs more than two complete frames and compares every pixel's address, colour and sync levels with values it computes from the raster position. A reset in the middle of a line then shows that the pipeline refills without carrying stale colour forward.

// File: rtl/img_window_scan.sv
module img_window_scan #(
  parameter int H_ACT  = 640,
  parameter int H_FP   = 16,
  parameter int H_SW   = 96,
  parameter int H_BP   = 48,
  parameter int V_ACT  = 480,
  parameter int V_FP   = 10,
  parameter int V_SW   = 2,
  parameter int V_BP   = 33,
  parameter int PIC_W  = 300,
  parameter int PIC_H  = 300,
  parameter int DIV    = 4,
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  output logic              pix_ce,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic [11:0]       rgb,
  output logic [ADDR_W-1:0] rom_addr,
  input  logic [11:0]       rom_data
);
  localparam int H_TOT     = H_ACT + H_FP + H_SW + H_BP;
  localparam int V_TOT     = V_ACT + V_FP + V_SW + V_BP;
  localparam int HW        = $clog2(H_TOT);
  localparam int VW        = $clog2(V_TOT);
  localparam int DW        = $clog2(DIV);
  localparam int HS_BEG    = H_ACT + H_FP;
  localparam int HS_END    = HS_BEG + H_SW;
  localparam int VS_BEG    = V_ACT + V_FP;
  localparam int VS_END    = VS_BEG + V_SW;
  localparam int PIC_WORDS = PIC_W * PIC_H;

  logic [DW-1:0]     div_q;
  logic [HW-1:0]     hcnt;
  logic [VW-1:0]     vcnt;
  logic [ADDR_W-1:0] row_base;
  logic [2:0]        stg1, stg2;   // {hsync, vsync, window}, active high

  assign pix_ce = (div_q == DW'(DIV - 1));

  wire line_end  = (32'(hcnt) == H_TOT - 1);
  wire frame_end = line_end && (32'(vcnt) == V_TOT - 1);
  wire in_win    = (32'(hcnt) < PIC_W) && (32'(vcnt) < PIC_H);
  wire hs_now    = (32'(hcnt) >= HS_BEG) && (32'(hcnt) < HS_END);
  wire vs_now    = (32'(vcnt) >= VS_BEG) && (32'(vcnt) < VS_END);

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= pix_ce ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt     <= '0;
      vcnt     <= '0;
      row_base <= '0;
    end else if (pix_ce) begin
      hcnt <= line_end ? '0 : hcnt + 1'b1;
      if (line_end) begin
        vcnt <= frame_end ? '0 : vcnt + 1'b1;
        if (frame_end)                row_base <= '0;
        else if (32'(vcnt) < PIC_H-1) row_base <= row_base + ADDR_W'(PIC_W);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_addr <= '0;
      stg1     <= '0;
      stg2     <= '0;
      hsync_n  <= 1'b1;
      vsync_n  <= 1'b1;
      rgb      <= '0;
    end else if (pix_ce) begin
      rom_addr <= in_win ? row_base + ADDR_W'(hcnt) : '0;
      stg1     <= {hs_now, vs_now, in_win};
      stg2     <= stg1;
      hsync_n  <= ~stg2[2];
      vsync_n  <= ~stg2[1];
      rgb      <= stg2[0] ? rom_data : '0;
    end
  end

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(pix_ce) |-> ($stable(rgb) && $stable(hsync_n) && $stable(vsync_n)));

  // R3
  hcnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    32'(hcnt) < H_TOT);

  // R6
  addr_range_chk: assert property (@(posedge clk) disable iff (rst)
    32'(rom_addr) < PIC_WORDS);

  // R5
  base_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (vcnt == '0) |-> (row_base == '0));

  // R5
  base_step_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_ce && line_end && (32'(vcnt) < PIC_H-1)) |=>
      (row_base == $past(row_base) + ADDR_W'(PIC_W)));
endmodule

// File: tb/tb_img_window_scan.sv
module tb_img_window_scan;
  localparam int TH_ACT = 12, TH_FP = 2, TH_SW = 3, TH_BP = 2;
  localparam int TV_ACT = 8,  TV_FP = 1, TV_SW = 2, TV_BP = 2;
  localparam int TPW = 5, TPH = 4, TDIV = 4, TAW = 17;
  localparam int TH_TOT = TH_ACT + TH_FP + TH_SW + TH_BP;
  localparam int TV_TOT = TV_ACT + TV_FP + TV_SW + TV_BP;
  localparam int FRAME  = TH_TOT * TV_TOT;

  // probe table: {column, line, hsync_n, vsync_n, in window}
  localparam int PROBE [12][5] = '{
    '{0, 0, 1,1,1}, '{4, 0, 1,1,1}, '{5, 0, 1,1,0}, '{14, 0, 0,1,0},
    '{16,0, 0,1,0}, '{17,0, 1,1,0}, '{0, 1, 1,1,1}, '{4, 3, 1,1,1},
    '{0, 4, 1,1,0}, '{3, 9, 1,0,0}, '{15,10,0,0,0}, '{0, 11,1,1,0}};

  logic clk = 0, rst = 1;
  logic pix_ce, hsync_n, vsync_n;
  logic [11:0] rgb, rom_q = '0;
  logic [TAW-1:0] rom_addr;

  int checks = 0, errors = 0, ncount = 0;
  bit mon_en = 0, primed = 0, done = 0;

  always #10 clk = ~clk;

  img_window_scan #(
    .H_ACT(TH_ACT), .H_FP(TH_FP), .H_SW(TH_SW), .H_BP(TH_BP),
    .V_ACT(TV_ACT), .V_FP(TV_FP), .V_SW(TV_SW), .V_BP(TV_BP),
    .PIC_W(TPW), .PIC_H(TPH), .DIV(TDIV), .ADDR_W(TAW)
  ) dut (
    .clk(clk), .rst(rst), .pix_ce(pix_ce), .hsync_n(hsync_n),
    .vsync_n(vsync_n), .rgb(rgb), .rom_addr(rom_addr), .rom_data(rom_q));

  function automatic logic [11:0] romf(input int a);
    return 12'((a * 37 + 257) % 4096);
  endfunction

  always @(posedge clk) if (pix_ce) rom_q <= romf(int'(rom_addr));

  always @(posedge clk) begin
    if (rst)         ncount <= 0;
    else if (pix_ce) ncount <= ncount + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic void expect_pix(input int p, output bit hs, output bit vs,
                                     output int col, output int addr);
    int h, v;
    bit w;
    if (p < 0) begin hs = 1; vs = 1; col = 0; addr = 0; return; end
    h = p % TH_TOT;
    v = (p / TH_TOT) % TV_TOT;
    hs = !(h >= TH_ACT + TH_FP && h < TH_ACT + TH_FP + TH_SW);
    vs = !(v >= TV_ACT + TV_FP && v < TV_ACT + TV_FP + TV_SW);
    w = (h < TPW) && (v < TPH);
    addr = w ? v * TPW + h : 0;
    col = w ? int'(romf(addr)) : 0;
  endfunction

  int last_n, gap;
  bit gap_seen;
  logic [11:0] prev_rgb;
  logic prev_hs, prev_vs;

  always @(negedge clk) begin
    if (!mon_en) begin
      primed = 0;
      gap_seen = 0;
    end else begin
      bit ehs, evs, dh, dv;
      int ecol, eaddr, da, dc;
      if (pix_ce) begin
        if (gap_seen) chk(gap == TDIV, "R1 strobe spacing", gap, TDIV);
        gap_seen = 1;
        gap = 1;
      end else gap++;
      if (primed) begin
        if (ncount != last_n) begin
          expect_pix(ncount - 3, ehs, evs, ecol, da);
          chk(hsync_n == ehs, "R3 hsync_n", int'(hsync_n), int'(ehs));
          chk(vsync_n == evs, "R4 vsync_n", int'(vsync_n), int'(evs));
          chk(int'(rgb) == ecol, ecol != 0 ? "R7 colour" : "R8 black",
              int'(rgb), ecol);
          expect_pix(ncount - 1, dh, dv, dc, eaddr);
          chk(int'(rom_addr) == eaddr, eaddr != 0 ? "R5 address" : "R6 address",
              int'(rom_addr), eaddr);
        end else begin
          chk(rgb == prev_rgb && hsync_n == prev_hs && vsync_n == prev_vs,
              "R9 hold between strobes", int'(rgb), int'(prev_rgb));
        end
      end
      primed = 1;
      last_n = ncount;
      prev_rgb = rgb;
      prev_hs = hsync_n;
      prev_vs = vsync_n;
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2: reset state
    chk(hsync_n == 1 && vsync_n == 1, "R2 sync idle", int'({hsync_n, vsync_n}), 3);
    chk(rgb == 0 && rom_addr == 0 && pix_ce == 0, "R2 outputs zero", int'(rgb), 0);
    rst = 0;
    mon_en = 1;
    for (int i = 0; i < 12; i++) begin
      int tgt, ecol;
      tgt = PROBE[i][1] * TH_TOT + PROBE[i][0];
      while (ncount - 3 < tgt) @(negedge clk);
      ecol = PROBE[i][4] != 0 ? int'(romf(PROBE[i][1] * TPW + PROBE[i][0])) : 0;
      chk(int'(hsync_n) == PROBE[i][2], "R3 probe hsync_n", int'(hsync_n), PROBE[i][2]);
      chk(int'(vsync_n) == PROBE[i][3], "R4 probe vsync_n", int'(vsync_n), PROBE[i][3]);
      chk(int'(rgb) == ecol, "R7 R8 probe colour", int'(rgb), ecol);
    end
    while (ncount < 2 * FRAME + 40) @(negedge clk);
    // mid-line reset, R2
    mon_en = 0;
    rst = 1;
    @(negedge clk);
    chk(hsync_n == 1 && vsync_n == 1, "R2 mid-run sync idle", int'({hsync_n, vsync_n}), 3);
    chk(rgb == 0, "R2 mid-run colour", int'(rgb), 0);
    chk(rom_addr == 0, "R2 mid-run address", int'(rom_addr), 0);
    repeat (2) @(negedge clk);
    rst = 0;
    mon_en = 1;
    while (ncount < FRAME + 30) @(negedge clk);
    finish_run();
  end
endmodule